// File: doc/BRIEF.md
# Boundary State-Metric Compression Memory

This block sits beside the backward-recursion engine of a sliding-window soft-input soft-output decoder. When the backward recursion of one iteration reaches a window boundary, the k state metrics found there are handed to the write port together with the boundary number. The block normalises them against state 0, turns each of the remaining k−1 metrics into a 3-bit code by comparing it with six programmable thresholds, and keeps only those codes. When the next iteration starts the backward recursion of the same window, the read port is given the boundary number. One clock later it returns k metrics rebuilt from the codes through a programmable table of reconstruction levels. State 0 always comes back as zero.

Storage per boundary is 3×(k−1) bits instead of k full-width metrics. After reset, or after the clear input, every boundary reads as all zeros (equiprobable start) until it has been written again. This covers the first iteration of a new code block with no extra control.

Top module: `bmc_top`

## Requirements
- R1: Slot 0 of `rd_metrics` (bits [MW-1:0], the reference state) is always zero.
- R2: For state i in 1..K-1, d = m_i − m_0 is formed without wrap-around. It is compared with threshold j held in `thr_cfg[j*MW +: MW]` (signed, j = 0..5, ascending). The code is one plus the highest j with d ≥ threshold j, or 0 if none, so it saturates at 0 and 6.
- R3: The rebuilt metric of state i is the signed level in `lvl_cfg[c*MW +: MW]` for its code c. It appears in `rd_metrics[i*MW +: MW]`.
- R4: A read issued with `rd_en` high at a clock edge updates `rd_metrics` at that same edge, which gives one clock of latency.
- R5: While `rd_en` is low, `rd_metrics` holds its value.
- R6: A boundary not written since reset or the last clear reads as all zeros.
- R7: `clr` invalidates every boundary. A read in the same cycle as `clr` returns zeros, and a write in the same cycle as `clr` is discarded.
- R8: A write and a read of the same boundary in the same cycle return the contents stored before that write. The new contents are seen by the next read.
- R9: Boundaries 0..NB-1 are stored independently, including the last index.
- R10: Thresholds are applied when the codes are written. Levels are applied when the codes are read.
- R11: During reset, `rd_metrics` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Invalidate all stored boundaries |
| wr_en | input | 1 | Store the metrics on `wr_metrics` |
| wr_idx | input | IW | Boundary number for the write |
| wr_metrics | input | K*MW | k signed metrics, state i in bits [i*MW +: MW] |
| rd_en | input | 1 | Load `rd_metrics` from a boundary |
| rd_idx | input | IW | Boundary number for the read |
| thr_cfg | input | NTHR*MW | Six signed comparison thresholds |
| lvl_cfg | input | NLVL*MW | Seven signed reconstruction levels, one per code |
| rd_metrics | output | K*MW | Rebuilt metrics, state i in bits [i*MW +: MW] |

## Verification
The hardest cases to reach from the ports are those where two events land in one cycle and their order matters: a read that meets a write of the same boundary, and a clear that meets a read or a write. The bench drives these pairs in the same low clock phase and then reads back in later cycles, so the old contents, the discarded write and the invalidation are each seen at `rd_metrics`. The saturating ends of the encoder and the full-range difference are reached with the reference metric at the two extremes of the signed range. Changing a threshold between writes and a level between write and read separates the point where each setting takes effect.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
    localparam int K    = 8;
    localparam int MW   = 10;
    localparam int NB   = 16;
    localparam int CW   = 3;
    localparam int NTHR = 6;
    localparam int NLVL = NTHR + 1;
    localparam int IW   = (NB > 1) ? $clog2(NB) : 1;
    localparam int DW   = MW + 1;

    typedef logic signed [MW-1:0] metric_t;
    typedef logic signed [DW-1:0] diff_t;
    typedef logic [CW-1:0]        code_t;
    typedef code_t [K-2:0]        codes_t;

    typedef struct packed {
        logic   vld;
        codes_t codes;
    } slot_rd_t;

    function automatic code_t therm_to_code(input logic [NTHR-1:0] t);
        code_t c;
        c = '0;
        for (int j = 0; j < NTHR; j++) begin
            if (t[j]) c = code_t'(j + 1);
        end
        return c;
    endfunction
endpackage

// File: rtl/bmc_encoder.sv
module bmc_encoder
    import bmc_pkg::*;
(
    input  logic [K*MW-1:0]    metrics,
    input  logic [NTHR*MW-1:0] thr,
    output codes_t             codes
);
    diff_t ref_m;
    assign ref_m = diff_t'($signed(metrics[MW-1:0]));

    for (genvar i = 1; i < K; i++) begin : g_st
        diff_t           d;
        logic [NTHR-1:0] t;
        assign d = diff_t'($signed(metrics[i*MW +: MW])) - ref_m;
        for (genvar j = 0; j < NTHR; j++) begin : g_th
            assign t[j] = (d >= diff_t'($signed(thr[j*MW +: MW])));
        end
        assign codes[i-1] = therm_to_code(t);
    end
endmodule

// File: rtl/bmc_store.sv
module bmc_store
    import bmc_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  codes_t        wr_codes,
    input  logic [IW-1:0] rd_idx,
    output slot_rd_t      rd_slot
);
    codes_t          mem [NB];
    logic [NB-1:0]   vld;
    logic            wr_ok;
    logic            rd_ok;

    assign wr_ok = wr_en && !clr && (int'(wr_idx) < NB);
    assign rd_ok = (int'(rd_idx) < NB);

    always_ff @(posedge clk) begin
        if (wr_ok) mem[wr_idx] <= wr_codes;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            vld <= '0;
        end else if (wr_ok) begin
            vld[wr_idx] <= 1'b1;
        end
    end

    always_comb begin
        rd_slot.codes = rd_ok ? mem[rd_idx] : '0;
        rd_slot.vld   = rd_ok && vld[rd_idx] && !clr;
    end
endmodule

// File: rtl/bmc_recover.sv
module bmc_recover
    import bmc_pkg::*;
(
    input  slot_rd_t           slot,
    input  logic [NLVL*MW-1:0] lvl,
    output logic [K*MW-1:0]    metrics
);
    assign metrics[MW-1:0] = '0;

    for (genvar i = 1; i < K; i++) begin : g_st
        int sel;
        always_comb begin
            sel = int'(slot.codes[i-1]);
            if (sel >= NLVL) sel = NLVL - 1;
        end
        assign metrics[i*MW +: MW] = slot.vld ? lvl[sel*MW +: MW] : '0;
    end
endmodule

// File: rtl/bmc_top.sv
module bmc_top
    import bmc_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               clr,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  logic [K*MW-1:0]    wr_metrics,
    input  logic               rd_en,
    input  logic [IW-1:0]      rd_idx,
    input  logic [NTHR*MW-1:0] thr_cfg,
    input  logic [NLVL*MW-1:0] lvl_cfg,
    output logic [K*MW-1:0]    rd_metrics
);
    codes_t          enc_codes;
    slot_rd_t        rd_slot;
    logic [K*MW-1:0] rebuilt;

    bmc_encoder u_enc (
        .metrics (wr_metrics),
        .thr     (thr_cfg),
        .codes   (enc_codes)
    );

    bmc_store u_mem (
        .clk      (clk),
        .rst      (rst),
        .clr      (clr),
        .wr_en    (wr_en),
        .wr_idx   (wr_idx),
        .wr_codes (enc_codes),
        .rd_idx   (rd_idx),
        .rd_slot  (rd_slot)
    );

    bmc_recover u_rec (
        .slot    (rd_slot),
        .lvl     (lvl_cfg),
        .metrics (rebuilt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_metrics <= '0;
        end else if (rd_en) begin
            rd_metrics <= rebuilt;
        end
    end
endmodule

// File: rtl/bmc_chk.sv
module bmc_chk
    import bmc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            clr,
    input logic            wr_en,
    input logic [IW-1:0]   wr_idx,
    input logic            rd_en,
    input logic [IW-1:0]   rd_idx,
    input logic [K*MW-1:0] rd_metrics
);
    logic [NB-1:0] seen;
    logic          rd_blank;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            seen <= '0;
        end else if (wr_en && int'(wr_idx) < NB) begin
            seen[wr_idx] <= 1'b1;
        end
    end

    assign rd_blank = rd_en && (clr || int'(rd_idx) >= NB || !seen[rd_idx]);

    // R1
    a_r1_ref_state_zero: assert property (@(posedge clk) disable iff (rst)
        rd_metrics[MW-1:0] == '0);

    // R6
    a_r6_unwritten_reads_zero: assert property (@(posedge clk) disable iff (rst)
        rd_blank |=> rd_metrics == '0);

    // R7
    a_r7_clear_read_zero: assert property (@(posedge clk) disable iff (rst)
        (clr && rd_en) |=> rd_metrics == '0);

    // R5
    a_r5_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(rd_metrics));

    // R11
    a_r11_reset_zero: assert property (@(posedge clk)
        rst |=> rd_metrics == '0);
endmodule

bind bmc_top bmc_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .clr        (clr),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .rd_en      (rd_en),
    .rd_idx     (rd_idx),
    .rd_metrics (rd_metrics)
);

// File: tb/sim_bmc_top.sv
module sim_bmc_top;
    import bmc_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               clr = 1'b0;
    logic               wr_en = 1'b0;
    logic [IW-1:0]      wr_idx = '0;
    logic [K*MW-1:0]    wr_metrics = '0;
    logic               rd_en = 1'b0;
    logic [IW-1:0]      rd_idx = '0;
    logic [NTHR*MW-1:0] thr_cfg;
    logic [NLVL*MW-1:0] lvl_cfg;
    logic [K*MW-1:0]    rd_metrics;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    localparam int THR_D [NTHR] = '{-96, -48, -16, 16, 48, 96};
    localparam int LVL_D [NLVL] = '{-96, -72, -32, 0, 32, 72, 96};

    // row: m0, d1..d7, expected e1..e7 (m_i = m0 + d_i)
    localparam int NV = 4;
    localparam int VEC [NV][15] = '{
        '{ 100, -200,  -96,  -97,  -48,  -16,   16,   95,
                 -96,  -72,  -96,  -32,    0,   32,   72},
        '{-300,  300,  500,  -15,   15,   47,   48,   96,
                  96,   96,    0,    0,   32,   72,   96},
        '{ 511, -1023, -511, -600, -100,  -50,    0,  -20,
                 -96,  -96,  -96,  -96,  -72,    0,  -32},
        '{-512, 1023,    0,    1,   16,  200,   60,   30,
                  96,    0,    0,   32,   96,   72,   32}
    };

    bmc_top u0 (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_metrics (wr_metrics),
        .rd_en      (rd_en),
        .rd_idx     (rd_idx),
        .thr_cfg    (thr_cfg),
        .lvl_cfg    (lvl_cfg),
        .rd_metrics (rd_metrics)
    );

    always #10 clk = ~clk;

    function automatic logic [K*MW-1:0] row_vec(input int r);
        logic [K*MW-1:0] v;
        v[MW-1:0] = metric_t'(VEC[r][0]);
        for (int i = 1; i < K; i++) v[i*MW +: MW] = metric_t'(VEC[r][0] + VEC[r][i]);
        return v;
    endfunction

    task automatic set_defaults();
        for (int j = 0; j < NTHR; j++) thr_cfg[j*MW +: MW] = metric_t'(THR_D[j]);
        for (int j = 0; j < NLVL; j++) lvl_cfg[j*MW +: MW] = metric_t'(LVL_D[j]);
    endtask

    task automatic check(input string req, input int slot, input int exp);
        int got;
        got = int'($signed(rd_metrics[slot*MW +: MW]));
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s state %0d actual %0d expected %0d", req, slot, got, exp);
        end
    endtask

    task automatic check_zero(input string req);
        for (int i = 0; i < K; i++) check(req, i, 0);
    endtask

    task automatic check_row(input string req, input int r);
        check(req, 0, 0);
        for (int i = 1; i < K; i++) check(req, i, VEC[r][7 + i]);
    endtask

    task automatic wr(input int idx, input logic [K*MW-1:0] v);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_metrics = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int idx);
        @(negedge clk);
        rd_en = 1'b1; rd_idx = IW'(idx);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic [K*MW-1:0] v;
        set_defaults();
        repeat (4) @(negedge clk);
        // R11: output zero during reset
        check_zero("R11");
        rst = 1'b0;

        // R6: boundary never written reads zero
        rd(5);
        check_zero("R6");

        // R2 R3 R4 R1: table of vectors, each on its own boundary
        for (int r = 0; r < NV; r++) begin
            wr(r + 2, row_vec(r));
            rd(r + 2);
            check_row("R2_R3_R4", r);
        end

        // R9: earlier boundaries were not disturbed; last index works
        rd(2);
        check_row("R9", 0);
        wr(NB - 1, row_vec(3));
        rd(NB - 1);
        check_row("R9", 3);
        rd(3);
        check_row("R9", 1);

        // R8: same-cycle write and read of boundary 1
        wr(1, row_vec(0));
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(1); wr_metrics = row_vec(1);
        rd_en = 1'b1; rd_idx = IW'(1);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        check_row("R8", 0);
        rd(1);
        check_row("R8", 1);

        // R5: output holds while rd_en is low, even with writes
        wr(1, row_vec(2));
        repeat (3) @(negedge clk);
        check_row("R5", 1);
        rd(1);
        check_row("R5", 2);

        // R10: threshold applies at write time
        thr_cfg[3*MW +: MW] = metric_t'(40);
        v = '0;
        v[1*MW +: MW] = metric_t'(20);
        wr(9, v);
        set_defaults();
        rd(9);
        check("R10", 1, 0);
        check("R10", 2, 0);
        // R10: level applies at read time
        wr(10, row_vec(0));
        lvl_cfg[0 +: MW] = metric_t'(-120);
        rd(10);
        check("R10", 1, -120);
        check("R10", 3, -120);
        check("R10", 2, -72);
        set_defaults();

        // R7: clear with a read in the same cycle
        @(negedge clk);
        clr = 1'b1; rd_en = 1'b1; rd_idx = IW'(2);
        @(negedge clk);
        clr = 1'b0; rd_en = 1'b0;
        check_zero("R7");
        rd(3);
        check_zero("R7");
        // R7: write during clear is discarded
        @(negedge clk);
        clr = 1'b1; wr_en = 1'b1; wr_idx = IW'(4); wr_metrics = row_vec(1);
        @(negedge clk);
        clr = 1'b0; wr_en = 1'b0;
        rd(4);
        check_zero("R7");
        // R6: rewrite after clear restores normal reads
        wr(4, row_vec(1));
        rd(4);
        check_row("R6", 1);

        done = 1;
        finish_run();
    end
endmodule